// File: doc/BRIEF.md
# Inset Picture Decimator

This block shrinks a digital component video stream into a small inset picture. Luma and the two colour-difference components arrive as 6-bit samples, one pixel per cycle whenever `pix_valid` is high. Single-cycle `hsync` and `vsync` pulses mark the start of each line and each field. The block averages groups of adjacent pixels along a line and groups of adjacent lines within a field. The horizontal and vertical ratios are chosen independently, so the picture can also be squeezed for aspect-ratio conversion. It emits one write strobe for each output sample, in a form that a field store behind it can consume directly.

Chroma is reduced four times further than luma along the line. Each chroma result is sent as a pair on one shared 6-bit bus: the blue difference first, then the red difference. Lines are counted from the field sync, not against a fixed total, so fields of either common broadcast line count are handled in the same way.

Control is a three-state machine:
- SEEK_FIELD is the state after reset.
- A `vsync` in any state moves it to SEEK_LINE, restarts the line phase and latches the ratios.
- An `hsync` in SEEK_LINE opens the first line and moves it to ACTIVE.
- In ACTIVE, each `hsync` closes the current line, opens the next one and advances the line phase.

Top module: `inset_decimator`

## Requirements
- R1: The ratio codes `h_ratio` and `v_ratio` map as follows: 0 gives 2:1, 1 gives 3:1, 2 gives 4:1 and 3 gives 6:1. The two axes are chosen independently, and both codes are sampled only in the cycle where `vsync` is high, so a change later in the field has no effect until the next field.
- R2: Each horizontal luma mean is the truncated average of H consecutive accepted luma pixels of one line, where H is the horizontal ratio. A `y_we` strobe appears in the cycle after the pixel that completes the final group contribution.
- R3: Lines are numbered from 0 after each `vsync`, and the line phase cycles through 0 to V-1, where V is the vertical ratio. Each luma output equals floor(sum of the V horizontal means at that position / V). Outputs are emitted only during the line whose phase is V-1.
- R4: Each chroma mean averages 4·H accepted pixels horizontally and then V lines in the same way as luma. The result is written as two strobes on consecutive cycles: the B-Y value with `c_sel`=0, then the R-Y value with `c_sel`=1.
- R5: A horizontal group left incomplete at a sync produces no output. Lines left over at a `vsync` after the last complete group of V lines produce no output.
- R6: At most LINE_MAX luma outputs (default 288) and LINE_MAX/4 chroma pairs (default 72) are produced per output line. Pixels beyond these limits are ignored.
- R7: While `freeze` is high, no `y_we` or `c_we` strobe is issued for a pixel presented in that cycle, and an R-Y strobe whose B-Y strobe was suppressed is also suppressed. The line and field markers continue.
- R8: `line_mark` pulses for one cycle after an `hsync` that closes a line of phase V-1.
- R9: `field_mark` pulses for one cycle after every `vsync`. `vsync` takes priority over `hsync`, and a pixel presented with either sync is ignored.
- R10: After reset, all strobes and markers are low. No sample is written before the first `vsync` followed by an `hsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset |
| pix_valid | input | 1 | A pixel is present this cycle |
| hsync | input | 1 | Line start pulse |
| vsync | input | 1 | Field start pulse |
| y_in | input | 6 | Luma sample |
| cb_in | input | 6 | B-Y sample |
| cr_in | input | 6 | R-Y sample |
| h_ratio | input | 2 | Horizontal ratio code |
| v_ratio | input | 2 | Vertical ratio code |
| freeze | input | 1 | Suppress all write strobes |
| y_out | output | 6 | Decimated luma |
| y_we | output | 1 | Luma write strobe |
| c_out | output | 6 | Decimated chroma (interleaved) |
| c_we | output | 1 | Chroma write strobe |
| c_sel | output | 1 | 0 = B-Y, 1 = R-Y |
| line_mark | output | 1 | Output line completed |
| field_mark | output | 1 | Field started |

## Verification
The bench runs fields at every ratio pairing, with line lengths and line counts that leave incomplete horizontal and vertical groups. A design that flushed those remainders would produce extra samples, and a wrong division would give wrong values under the truncated mean-of-means rule. A ratio change just after `vsync` catches a design that reads the ratio live; such a design would produce the wrong number of samples. An over-long line catches a missing capacity limit, which would run past the line store. A frozen field must show line markers but no strobes. The chroma stream is checked for strict B-Y/R-Y adjacency, which catches a misordered or split pair.

// File: rtl/inset_decimator_pkg.sv
package inset_decimator_pkg;

    typedef enum logic [1:0] {
        ST_SEEK_FIELD = 2'd0,
        ST_SEEK_LINE  = 2'd1,
        ST_ACTIVE     = 2'd2
    } dec_state_e;

    // ratio code to group length
    function automatic logic [2:0] ratio_len(input logic [1:0] code);
        logic [2:0] n;
        case (code)
            2'd0:    n = 3'd2;
            2'd1:    n = 3'd3;
            2'd2:    n = 3'd4;
            default: n = 3'd6;
        endcase
        return n;
    endfunction

    // division by one of the few group lengths that can occur
    function automatic logic [5:0] div_group(input logic [11:0] s, input logic [4:0] n);
        logic [11:0] q;
        case (n)
            5'd2:    q = s / 12'd2;
            5'd3:    q = s / 12'd3;
            5'd4:    q = s / 12'd4;
            5'd6:    q = s / 12'd6;
            5'd8:    q = s / 12'd8;
            5'd12:   q = s / 12'd12;
            5'd16:   q = s / 12'd16;
            5'd24:   q = s / 12'd24;
            default: q = 12'd0;
        endcase
        return q[5:0];
    endfunction

endpackage

// File: rtl/inset_decimator_hacc.sv
module inset_decimator_hacc #(
    parameter int LANES = 1,
    parameter int DW    = 6,
    parameter int SUM_W = 12,
    parameter int CNT_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        take,
    input  logic [CNT_W-1:0]            glen,
    input  logic [LANES-1:0][DW-1:0]    din,
    output logic                        done,
    output logic [LANES-1:0][SUM_W-1:0] sum
);

    logic [CNT_W-1:0] cnt_q;

    assign done = take && (cnt_q == glen - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= done ? '0 : cnt_q + CNT_W'(1);
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [SUM_W-1:0] acc_q;

        assign sum[l] = acc_q + SUM_W'(din[l]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (clr) begin
                acc_q <= '0;
            end else if (take) begin
                acc_q <= done ? '0 : sum[l];
            end
        end
    end

endmodule

// File: rtl/inset_decimator_vacc.sv
module inset_decimator_vacc #(
    parameter int DW    = 6,
    parameter int DEPTH = 288,
    parameter int SUM_W = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] pos,
    input  logic          first,
    input  logic          last,
    input  logic [2:0]    vlen,
    input  logic [DW-1:0] mean,
    output logic          fire,
    output logic [DW-1:0] avg
);
    import inset_decimator_pkg::*;

    localparam int TW = 12;

    logic [SUM_W-1:0] line_buf [DEPTH];
    logic [TW-1:0]    total;

    assign total = TW'(line_buf[pos]) + TW'(mean);
    assign fire  = en && last;
    assign avg   = div_group(total, {2'b00, vlen});

    always_ff @(posedge clk) begin
        if (en && !last) begin
            line_buf[pos] <= first ? SUM_W'(mean) : total[SUM_W-1:0];
        end
    end

endmodule

// File: rtl/inset_decimator.sv
module inset_decimator #(
    parameter int PIX_W    = 6,
    parameter int LINE_MAX = 288
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             hsync,
    input  logic             vsync,
    input  logic [PIX_W-1:0] y_in,
    input  logic [PIX_W-1:0] cb_in,
    input  logic [PIX_W-1:0] cr_in,
    input  logic [1:0]       h_ratio,
    input  logic [1:0]       v_ratio,
    input  logic             freeze,
    output logic [PIX_W-1:0] y_out,
    output logic             y_we,
    output logic [PIX_W-1:0] c_out,
    output logic             c_we,
    output logic             c_sel,
    output logic             line_mark,
    output logic             field_mark
);
    import inset_decimator_pkg::*;

    localparam int CHROMA_MAX = LINE_MAX / 4;
    localparam int HPOS_W     = $clog2(LINE_MAX + 1);
    localparam int CPOS_W     = $clog2(CHROMA_MAX + 1);
    localparam int YAW        = $clog2(LINE_MAX);
    localparam int CAW        = $clog2(CHROMA_MAX);
    localparam int SUM_W      = 12;
    localparam int GLEN_W     = 5;
    localparam int VSUM_W     = 9;

    dec_state_e        state_q, state_d;
    logic [1:0]        hr_q, vr_q;
    logic [2:0]        vphase_q;
    logic [HPOS_W-1:0] hpos_q;
    logic [CPOS_W-1:0] cpos_q;
    logic [PIX_W-1:0]  cr_hold_q;
    logic              cr_pend_q;

    // control decoded from state
    logic              take_y, take_c, line_close, line_open, sync_any;
    logic [2:0]        hlen, vlen;
    logic              ph_first, ph_last;

    // datapath
    logic                          y_done, c_done;
    logic [0:0][SUM_W-1:0]         y_sum;
    logic [1:0][SUM_W-1:0]         c_sum;
    logic [PIX_W-1:0]              y_mean;
    logic [1:0][PIX_W-1:0]         c_mean;
    logic                          y_fire;
    logic [PIX_W-1:0]              y_avg;
    logic [1:0]                    c_fire;
    logic [1:0][PIX_W-1:0]         c_avg;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEEK_FIELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (vsync) begin
            state_d = ST_SEEK_LINE;
        end else begin
            unique case (state_q)
                ST_SEEK_FIELD: state_d = ST_SEEK_FIELD;
                ST_SEEK_LINE:  if (hsync) state_d = ST_ACTIVE;
                ST_ACTIVE:     state_d = ST_ACTIVE;
                default:       state_d = ST_SEEK_FIELD;
            endcase
        end
    end

    // ---------------- control outputs of the state ----------------
    always_comb begin
        hlen       = ratio_len(hr_q);
        vlen       = ratio_len(vr_q);
        ph_first   = (vphase_q == 3'd0);
        ph_last    = (vphase_q == vlen - 3'd1);
        sync_any   = hsync || vsync;
        take_y     = 1'b0;
        line_close = 1'b0;
        line_open  = 1'b0;
        unique case (state_q)
            ST_SEEK_FIELD: ;
            ST_SEEK_LINE:  line_open = hsync && !vsync;
            ST_ACTIVE: begin
                take_y     = pix_valid && !sync_any && (hpos_q < HPOS_W'(LINE_MAX));
                line_close = hsync && !vsync;
                line_open  = hsync && !vsync;
            end
            default: ;
        endcase
        take_c = take_y && (cpos_q < CPOS_W'(CHROMA_MAX));
    end

    // ---------------- horizontal accumulators ----------------
    inset_decimator_hacc #(
        .LANES(1), .DW(PIX_W), .SUM_W(SUM_W), .CNT_W(GLEN_W)
    ) u_hacc_y (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sync_any),
        .take (take_y),
        .glen ({2'b00, hlen}),
        .din  (y_in),
        .done (y_done),
        .sum  (y_sum)
    );

    inset_decimator_hacc #(
        .LANES(2), .DW(PIX_W), .SUM_W(SUM_W), .CNT_W(GLEN_W)
    ) u_hacc_c (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (sync_any),
        .take (take_c),
        .glen ({hlen, 2'b00}),
        .din  ({cr_in, cb_in}),
        .done (c_done),
        .sum  (c_sum)
    );

    assign y_mean = div_group(y_sum[0], {2'b00, hlen});

    // ---------------- vertical accumulators ----------------
    inset_decimator_vacc #(
        .DW(PIX_W), .DEPTH(LINE_MAX), .SUM_W(VSUM_W), .AW(YAW)
    ) u_vacc_y (
        .clk  (clk),
        .en   (y_done),
        .pos  (hpos_q[YAW-1:0]),
        .first(ph_first),
        .last (ph_last),
        .vlen (vlen),
        .mean (y_mean),
        .fire (y_fire),
        .avg  (y_avg)
    );

    for (genvar l = 0; l < 2; l++) begin : g_chroma
        assign c_mean[l] = div_group(c_sum[l], {hlen, 2'b00});

        inset_decimator_vacc #(
            .DW(PIX_W), .DEPTH(CHROMA_MAX), .SUM_W(VSUM_W), .AW(CAW)
        ) u_vacc_c (
            .clk  (clk),
            .en   (c_done),
            .pos  (cpos_q[CAW-1:0]),
            .first(ph_first),
            .last (ph_last),
            .vlen (vlen),
            .mean (c_mean[l]),
            .fire (c_fire[l]),
            .avg  (c_avg[l])
        );
    end

    // ---------------- counters and latched ratios ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hr_q     <= 2'd0;
            vr_q     <= 2'd0;
            vphase_q <= 3'd0;
            hpos_q   <= '0;
            cpos_q   <= '0;
        end else begin
            if (vsync) begin
                hr_q     <= h_ratio;
                vr_q     <= v_ratio;
                vphase_q <= 3'd0;
            end else if (line_close) begin
                vphase_q <= ph_last ? 3'd0 : vphase_q + 3'd1;
            end
            if (sync_any) begin
                hpos_q <= '0;
                cpos_q <= '0;
            end else begin
                if (y_done) hpos_q <= hpos_q + HPOS_W'(1);
                if (c_done) cpos_q <= cpos_q + CPOS_W'(1);
            end
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_out      <= '0;
            y_we       <= 1'b0;
            c_out      <= '0;
            c_we       <= 1'b0;
            c_sel      <= 1'b0;
            cr_hold_q  <= '0;
            cr_pend_q  <= 1'b0;
            line_mark  <= 1'b0;
            field_mark <= 1'b0;
        end else begin
            y_we <= y_fire && !freeze;
            if (y_fire) y_out <= y_avg;

            if (c_fire[0]) begin
                c_out     <= c_avg[0];
                c_sel     <= 1'b0;
                c_we      <= !freeze;
                cr_hold_q <= c_avg[1];
                cr_pend_q <= !freeze;
            end else if (cr_pend_q) begin
                c_out     <= cr_hold_q;
                c_sel     <= 1'b1;
                c_we      <= 1'b1;
                cr_pend_q <= 1'b0;
            end else begin
                c_we      <= 1'b0;
            end

            line_mark  <= line_close && ph_last;
            field_mark <= vsync;
        end
    end

    logic unused_ok;
    assign unused_ok = line_open ^ c_fire[1];

endmodule

// File: rtl/inset_decimator_chk.sv
module inset_decimator_chk
    import inset_decimator_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       hsync,
    input logic       vsync,
    input logic       freeze,
    input logic       y_we,
    input logic       c_we,
    input logic       c_sel,
    input logic       line_mark,
    input logic       field_mark,
    input dec_state_e state,
    input logic [2:0] vphase,
    input logic [1:0] vcode
);

    AST_CR_AFTER_CB: assert property (@(posedge clk) disable iff (!rst_n)
        (c_we && !c_sel) |=> (c_we && c_sel));                              // R4

    AST_FREEZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && $past(freeze)) |=> (!y_we && !c_we));                   // R7

    AST_LINE_MARK_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        line_mark |-> $past(hsync));                                        // R8

    AST_FIELD_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> field_mark);                                              // R9

    AST_LUMA_LAST_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        y_we |-> (vphase == ratio_len(vcode) - 3'd1));                      // R3

    AST_QUIET_BEFORE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEEK_FIELD) |-> (!y_we && !c_we && !line_mark));       // R10

endmodule

bind inset_decimator inset_decimator_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hsync     (hsync),
    .vsync     (vsync),
    .freeze    (freeze),
    .y_we      (y_we),
    .c_we      (c_we),
    .c_sel     (c_sel),
    .line_mark (line_mark),
    .field_mark(field_mark),
    .state     (state_q),
    .vphase    (vphase_q),
    .vcode     (vr_q)
);

// File: tb/sim_inset_decimator.sv
module sim_inset_decimator;

    localparam int LMAX = 288;
    localparam int NV   = 8;
    // h code, v code, pixels per line, lines, seed, gaps
    localparam int VEC [NV][6] = '{
        '{1, 1,  72,  9, 1, 0},
        '{2, 1,  96, 10, 2, 0},
        '{1, 2,  75,  8, 3, 1},
        '{1, 0,  60,  7, 4, 0},
        '{0, 1,  50, 12, 5, 1},
        '{0, 0,  41,  6, 6, 0},
        '{3, 3, 100, 13, 7, 0},
        '{2, 2,  64,  9, 8, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_valid = 1'b0, hsync = 1'b0, vsync = 1'b0, freeze = 1'b0;
    logic [5:0] y_in = '0, cb_in = '0, cr_in = '0;
    logic [1:0] h_ratio = '0, v_ratio = '0;
    logic [5:0] y_out, c_out;
    logic       y_we, c_we, c_sel, line_mark, field_mark;

    int n_checks = 0, n_fail = 0, cyc = 0;
    int ny = 0, nc = 0, nl = 0, nf = 0;
    int y_got [1024];
    int c_got [1024];
    int c_sg  [1024];
    int c_cy  [1024];
    int ey [1024];
    int ec [1024];
    int ey_n, ec_n;

    always #5 clk = ~clk;

    inset_decimator u0 (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .hsync(hsync), .vsync(vsync),
        .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in), .h_ratio(h_ratio), .v_ratio(v_ratio),
        .freeze(freeze), .y_out(y_out), .y_we(y_we), .c_out(c_out), .c_we(c_we),
        .c_sel(c_sel), .line_mark(line_mark), .field_mark(field_mark)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (y_we && ny < 1024) begin y_got[ny] = int'(y_out); ny++; end
            if (c_we && nc < 1024) begin
                c_got[nc] = int'(c_out); c_sg[nc] = int'(c_sel); c_cy[nc] = cyc; nc++;
            end
            if (line_mark)  nl++;
            if (field_mark) nf++;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int py(int ln, int x, int s);  return (x*5 + ln*7 + s*11 + (x*ln) % 13) % 64; endfunction
    function automatic int pb(int ln, int x, int s);  return (x*3 + ln*2 + s*13 + 17) % 64;          endfunction
    function automatic int pr(int ln, int x, int s);  return 63 - ((x*9 + ln*5 + s) % 64);           endfunction
    function automatic int rl(int code);              return (code == 3) ? 6 : code + 2;             endfunction

    task automatic model(input int hc, input int vc, input int np, input int nln, input int s);
        int h, v, gy, gc;
        h = rl(hc); v = rl(vc);
        gy = np / h;       if (gy > LMAX)     gy = LMAX;
        gc = np / (4*h);   if (gc > LMAX / 4) gc = LMAX / 4;
        ey_n = 0; ec_n = 0;
        for (int j = 0; j < nln / v; j++) begin
            for (int g = 0; g < gy; g++) begin
                int acc = 0;
                for (int l = 0; l < v; l++) begin
                    int sm = 0;
                    for (int k = 0; k < h; k++) sm += py(j*v + l, g*h + k, s);
                    acc += sm / h;
                end
                ey[ey_n] = acc / v; ey_n++;
            end
            for (int g = 0; g < gc; g++) begin
                int ab = 0, ar = 0;
                for (int l = 0; l < v; l++) begin
                    int sb = 0, sr = 0;
                    for (int k = 0; k < 4*h; k++) begin
                        sb += pb(j*v + l, g*4*h + k, s);
                        sr += pr(j*v + l, g*4*h + k, s);
                    end
                    ab += sb / (4*h); ar += sr / (4*h);
                end
                ec[ec_n] = ab / v; ec[ec_n+1] = ar / v; ec_n += 2;
            end
        end
    endtask

    task automatic run_field(input int hc, input int vc, input int np, input int nln,
                             input int s, input int gaps, input bit frz, input bit chg);
        @(negedge clk);
        ny = 0; nc = 0; nl = 0; nf = 0;
        h_ratio = 2'(hc); v_ratio = 2'(vc); freeze = frz;
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
        if (chg) begin h_ratio = 2'(hc ^ 1); v_ratio = 2'(vc ^ 2); end
        for (int ln = 0; ln < nln; ln++) begin
            hsync = 1'b1;
            @(negedge clk);
            hsync = 1'b0;
            for (int x = 0; x < np; x++) begin
                if (gaps != 0 && x % 4 == 3) begin
                    pix_valid = 1'b0;
                    @(negedge clk);
                end
                pix_valid = 1'b1;
                y_in = 6'(py(ln, x, s)); cb_in = 6'(pb(ln, x, s)); cr_in = 6'(pr(ln, x, s));
                @(negedge clk);
            end
            pix_valid = 1'b0;
            @(negedge clk);
        end
        hsync = 1'b1;
        @(negedge clk);
        hsync = 1'b0;
        repeat (6) @(negedge clk);
        freeze = 1'b0;
    endtask

    task automatic compare(input int vc, input int nln);
        chk(ny == ey_n, "R3 R5 luma count", ny, ey_n);
        for (int i = 0; i < ny && i < ey_n; i++)
            chk(y_got[i] == ey[i], "R2 R3 luma value", y_got[i], ey[i]);
        chk(nc == ec_n, "R4 R5 chroma count", nc, ec_n);
        for (int i = 0; i < nc && i < ec_n; i++) begin
            chk(c_got[i] == ec[i], "R4 chroma value", c_got[i], ec[i]);
            chk(c_sg[i] == i % 2, "R4 chroma select order", c_sg[i], i % 2);
            if (i % 2 == 1) chk(c_cy[i] == c_cy[i-1] + 1, "R4 pair adjacency", c_cy[i] - c_cy[i-1], 1);
        end
        chk(nl == nln / rl(vc), "R8 line marks", nl, nln / rl(vc));
        chk(nf == 1, "R9 field marks", nf, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(y_we == 1'b0 && c_we == 1'b0, "R10 strobes low in reset", int'(y_we | c_we), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_mark == 1'b0 && field_mark == 1'b0, "R10 markers low after reset",
            int'(line_mark | field_mark), 0);
        // R10: lines without a field sync produce nothing
        ny = 0; nc = 0; nl = 0;
        h_ratio = 2'd0; v_ratio = 2'd0;
        for (int ln = 0; ln < 3; ln++) begin
            hsync = 1'b1; @(negedge clk); hsync = 1'b0;
            for (int x = 0; x < 20; x++) begin
                pix_valid = 1'b1; y_in = 6'(x); cb_in = 6'(x); cr_in = 6'(x);
                @(negedge clk);
            end
            pix_valid = 1'b0;
        end
        repeat (4) @(negedge clk);
        chk(ny + nc + nl == 0, "R10 no output before field sync", ny + nc + nl, 0);

        // table of ratio pairs and line shapes (R1 R2 R3 R4 R5 R8 R9)
        for (int t = 0; t < NV; t++) begin
            model(VEC[t][0], VEC[t][1], VEC[t][2], VEC[t][3], VEC[t][4]);
            run_field(VEC[t][0], VEC[t][1], VEC[t][2], VEC[t][3], VEC[t][4], VEC[t][5], 1'b0, 1'b0);
            compare(VEC[t][1], VEC[t][3]);
        end

        // R1: ratio inputs changed after vsync do not apply to the current field
        model(2, 1, 80, 9, 9);
        run_field(2, 1, 80, 9, 9, 0, 1'b0, 1'b1);
        chk(ny == ey_n, "R1 ratio latched at field sync", ny, ey_n);
        compare(1, 9);

        // R5: horizontal group larger than the line leaves chroma empty
        model(3, 0, 11, 4, 10);
        run_field(3, 0, 11, 4, 10, 0, 1'b0, 1'b0);
        chk(nc == 0, "R5 no chroma from partial group", nc, 0);
        chk(ny == 2, "R5 one luma per output line", ny, 2);

        // R6: capacity limit per line
        model(0, 0, 600, 2, 11);
        run_field(0, 0, 600, 2, 11, 0, 1'b0, 1'b0);
        chk(ny == LMAX, "R6 luma capacity", ny, LMAX);
        chk(nc == LMAX / 2, "R6 chroma capacity (pairs x2)", nc, LMAX / 2);
        compare(0, 2);

        // R7: freeze suppresses strobes but not markers
        run_field(1, 1, 48, 9, 12, 0, 1'b1, 1'b0);
        chk(ny == 0, "R7 no luma strobe while frozen", ny, 0);
        chk(nc == 0, "R7 no chroma strobe while frozen", nc, 0);
        chk(nl == 3, "R7 line marks continue while frozen", nl, 3);
        chk(nf == 1, "R7 field mark while frozen", nf, 1);

        summary();
        $finish;
    end

endmodule